// File: doc/BRIEF.md
# Graph Vertex Update Worker

This block is one worker among several that share a superstep-based rank computation over a graph. Vertices are dealt out round-robin, so a worker with index `WORKER_ID` among `NUM_WORKERS` owns every vertex whose number leaves that remainder. Each owned vertex keeps its rank in a memory local to the worker. While the master holds `compute` high, the worker visits its vertices in ascending order. For each one it asks for the neighbour-contribution sum with `sum_req` and the vertex number, and takes the sum on `sum_valid`. It then forms the new rank as a teleport term plus the sum scaled by a damping factor of 0.78125. That scaling uses only shifts and adds. Before the new rank is written, the worker reads the stored rank back and tests whether the vertex has converged.

After the last owned vertex has been stored, the worker raises `terminate` and reports through `vote_halt` whether every vertex converged in that pass. It keeps `terminate` high until the master drops `compute`. A pass in which all vertices converged also sets the sticky `halt` bit. From then on the worker ignores further `compute` commands, so all-ones across the workers' halt bits marks the end of the computation. Ranks are unsigned 32-bit fixed point with 28 fractional bits. After reset the worker loads the supplied initial rank into each local entry, one entry per cycle. Its local memory can be read through `rd_addr`/`rd_data` whenever it is not inside a pass.

Top module: `wvu_worker`

## Requirements
- R1: During a pass the worker requests sums for its owned vertices only. These are the vertex numbers v with v mod NUM_WORKERS == WORKER_ID, in ascending order, and each number appears on `vertex_idx` while `sum_req` is high.
- R2: While reset is high, `sum_req`, `terminate`, `vote_halt` and `halt` are low. After reset, every local entry holds `init_rank`, and the load takes one cycle per owned vertex.
- R3: The new rank of a vertex is `base_rank + (s>>1) + (s>>2) + (s>>5)`, where s is the sum taken on `sum_valid`. The shifts are logical on the unsigned sum.
- R4: The rank of vertex v is stored at local address v / NUM_WORKERS. Outside a pass, `rd_data` shows the entry at `rd_addr` one clock after the address is presented.
- R5: A vertex has converged when the absolute difference between its new and previous rank is at or below `conv_thresh`. A difference exactly equal to the threshold counts as converged. `vote_halt` is high after a pass only if every owned vertex converged in that pass.
- R6: With `compute` low the worker makes no sum requests. After its last vertex it raises `terminate` and holds it while `compute` stays high. It clears `terminate` on the clock edge at which `compute` is seen low.
- R7: `halt` is set at the end of a pass that voted to halt and stays set until reset. While `halt` is set, `compute` starts no pass and the stored ranks do not change.
- R8: A vertex whose contribution sum is zero receives exactly `base_rank`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compute | input | 1 | Master command: run a pass while high |
| sum_valid | input | 1 | Sum for the requested vertex is on `sum_in` |
| sum_in | input | RANK_W | Accumulated neighbour contribution sum |
| base_rank | input | RANK_W | Precomputed teleport term (1-d)/n |
| init_rank | input | RANK_W | Rank loaded into every entry after reset |
| conv_thresh | input | RANK_W | Convergence threshold on the absolute change |
| rd_addr | input | LOC_W | Local memory read address (outside a pass) |
| sum_req | output | 1 | Worker is waiting for the sum of `vertex_idx` |
| vertex_idx | output | VID_W | Global number of the vertex being updated |
| rd_data | output | RANK_W | Local memory read data, one-cycle latency |
| terminate | output | 1 | Pass finished, held until `compute` falls |
| vote_halt | output | 1 | All owned vertices converged in the last pass |
| halt | output | 1 | Sticky: worker has converged and stopped |

## Verification
The bound checker watches every cycle for rules that hold in any pass. Every requested vertex number must belong to this worker. No request may appear while halted or while `terminate` is up. `terminate` must stay up while `compute` stays high. `halt` must never fall and may rise only together with a vote. The rank arithmetic, the equal-to-threshold boundary, the one-vertex-not-converged vote, and the contents of the local memory after init and after each pass can only be shown by the bench. It drives passes with chosen sums and reads the stored ranks back through the read port.

// File: rtl/wvu_pkg.sv
package wvu_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_IDLE = 3'd1,
    ST_REQ  = 3'd2,
    ST_EVAL = 3'd3,
    ST_DONE = 3'd4
  } wvu_state_e;

endpackage

// File: rtl/wvu_rank_mem.sv
module wvu_rank_mem #(
  parameter int DEPTH = 2,
  parameter int DW    = 32,
  parameter int AW    = 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wvu_damp.sv
module wvu_damp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] sum,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] rank_new
);

  // d = 0.78125 = 1/2 + 1/4 + 1/32
  localparam int SH_A = 1;
  localparam int SH_B = 2;
  localparam int SH_C = 5;

  logic [DW-1:0] scaled;

  always_comb begin
    scaled = (sum >> SH_A) + (sum >> SH_B) + (sum >> SH_C);
  end

  always_ff @(posedge clk) begin
    if (rst)       rank_new <= '0;
    else if (load) rank_new <= base + scaled;
  end

endmodule

// File: rtl/wvu_conv_check.sv
module wvu_conv_check #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rank_new,
  input  logic [DW-1:0] rank_old,
  input  logic [DW-1:0] thresh,
  output logic          converged
);

  logic [DW-1:0] delta;

  always_comb begin
    delta     = (rank_new >= rank_old) ? (rank_new - rank_old) : (rank_old - rank_new);
    converged = (delta <= thresh);
  end

endmodule

// File: rtl/wvu_worker.sv
module wvu_worker
  import wvu_pkg::*;
#(
  parameter int NUM_WORKERS  = 3,
  parameter int WORKER_ID    = 0,
  parameter int NUM_VERTICES = 5,
  parameter int RANK_W       = 32,
  localparam int LOCAL_N = (NUM_VERTICES - WORKER_ID + NUM_WORKERS - 1) / NUM_WORKERS,
  localparam int LOC_W   = (LOCAL_N > 1) ? $clog2(LOCAL_N) : 1,
  localparam int VID_W   = (NUM_VERTICES > 1) ? $clog2(NUM_VERTICES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              compute,
  input  logic              sum_valid,
  input  logic [RANK_W-1:0] sum_in,
  input  logic [RANK_W-1:0] base_rank,
  input  logic [RANK_W-1:0] init_rank,
  input  logic [RANK_W-1:0] conv_thresh,
  input  logic [LOC_W-1:0]  rd_addr,
  output logic              sum_req,
  output logic [VID_W-1:0]  vertex_idx,
  output logic [RANK_W-1:0] rd_data,
  output logic              terminate,
  output logic              vote_halt,
  output logic              halt
);

  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(LOCAL_N - 1);

  wvu_state_e        state;
  logic [LOC_W-1:0]  loc;
  logic              all_conv;
  logic              term_q, vote_q, halt_q;

  logic              mem_we;
  logic [RANK_W-1:0] mem_wdata;
  logic [LOC_W-1:0]  mem_raddr;
  logic [RANK_W-1:0] mem_rdata;
  logic [RANK_W-1:0] rank_new;
  logic              conv_ok;
  logic              take_sum;

  always_comb begin
    take_sum  = (state == ST_REQ) && sum_valid;
    mem_we    = (state == ST_INIT) || (state == ST_EVAL);
    mem_wdata = (state == ST_INIT) ? init_rank : rank_new;
    mem_raddr = (state == ST_REQ) ? loc : rd_addr;
  end

  wvu_rank_mem #(.DEPTH(LOCAL_N), .DW(RANK_W), .AW(LOC_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (loc),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  wvu_damp #(.DW(RANK_W)) u_damp (
    .clk      (clk),
    .rst      (rst),
    .load     (take_sum),
    .sum      (sum_in),
    .base     (base_rank),
    .rank_new (rank_new)
  );

  wvu_conv_check #(.DW(RANK_W)) u_conv (
    .rank_new  (rank_new),
    .rank_old  (mem_rdata),
    .thresh    (conv_thresh),
    .converged (conv_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_INIT;
      loc      <= '0;
      all_conv <= 1'b1;
      term_q   <= 1'b0;
      vote_q   <= 1'b0;
      halt_q   <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          if (loc == LAST_LOC) begin
            loc   <= '0;
            state <= ST_IDLE;
          end else begin
            loc <= loc + 1'b1;
          end
        end
        ST_IDLE: begin
          if (compute && !halt_q) begin
            loc      <= '0;
            vote_q   <= 1'b0;
            all_conv <= 1'b1;
            state    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (sum_valid) state <= ST_EVAL;
        end
        ST_EVAL: begin
          all_conv <= all_conv & conv_ok;
          if (loc == LAST_LOC) begin
            term_q <= 1'b1;
            vote_q <= all_conv & conv_ok;
            halt_q <= halt_q | (all_conv & conv_ok);
            state  <= ST_DONE;
          end else begin
            loc   <= loc + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_DONE: begin
          if (!compute) begin
            term_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sum_req    = (state == ST_REQ);
    vertex_idx = VID_W'(int'(loc) * NUM_WORKERS + WORKER_ID);
    rd_data    = mem_rdata;
    terminate  = term_q;
    vote_halt  = vote_q;
    halt       = halt_q;
  end

endmodule

// File: rtl/wvu_worker_chk.sv
module wvu_worker_chk #(
  parameter int NUM_WORKERS = 3,
  parameter int WORKER_ID   = 0,
  parameter int VID_W       = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             compute,
  input logic             sum_req,
  input logic [VID_W-1:0] vertex_idx,
  input logic             terminate,
  input logic             vote_halt,
  input logic             halt
);

  // R1: requested vertex belongs to this worker
  p_owned_vertex_r1: assert property (@(posedge clk) disable iff (rst)
    sum_req |-> ((int'(vertex_idx) % NUM_WORKERS) == WORKER_ID));

  // R6: no request while a finished pass is being reported
  p_req_not_term_r6: assert property (@(posedge clk) disable iff (rst)
    !(sum_req && terminate));

  // R6: terminate held while compute stays high
  p_term_held_r6: assert property (@(posedge clk) disable iff (rst)
    (terminate && compute) |=> terminate);

  // R7: halt is sticky
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  // R7: a halted worker makes no requests
  p_no_req_halted_r7: assert property (@(posedge clk) disable iff (rst)
    halt |-> !sum_req);

  // R5: halt only rises at the end of a pass that voted
  p_halt_needs_vote_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> (vote_halt && terminate));

endmodule

bind wvu_worker wvu_worker_chk #(
  .NUM_WORKERS (NUM_WORKERS),
  .WORKER_ID   (WORKER_ID),
  .VID_W       (VID_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .compute    (compute),
  .sum_req    (sum_req),
  .vertex_idx (vertex_idx),
  .terminate  (terminate),
  .vote_halt  (vote_halt),
  .halt       (halt)
);

// File: tb/tb_wvu_worker.sv
module tb_wvu_worker;

  localparam int W   = 3;
  localparam int ID  = 0;
  localparam int NV  = 5;
  localparam int RW  = 32;
  localparam int NL  = 2;   // owned vertices: 0 and 3

  localparam logic [RW-1:0] INIT_R = 32'd53687091;  // ~1/5
  localparam logic [RW-1:0] BASE_R = 32'd11744051;  // ~0.21875/5
  localparam logic [RW-1:0] THR    = 32'd25;
  localparam logic [RW-1:0] SA0    = 32'h0100_0000;
  localparam logic [RW-1:0] SA1    = 32'h0080_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          compute = 1'b0;
  logic          sum_valid = 1'b0;
  logic [RW-1:0] sum_in = '0;
  logic [0:0]    rd_addr = '0;
  logic          sum_req, terminate, vote_halt, halt;
  logic [2:0]    vertex_idx;
  logic [RW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wvu_worker #(.NUM_WORKERS(W), .WORKER_ID(ID), .NUM_VERTICES(NV), .RANK_W(RW)) dut (
    .clk(clk), .rst(rst), .compute(compute), .sum_valid(sum_valid), .sum_in(sum_in),
    .base_rank(BASE_R), .init_rank(INIT_R), .conv_thresh(THR), .rd_addr(rd_addr),
    .sum_req(sum_req), .vertex_idx(vertex_idx), .rd_data(rd_data),
    .terminate(terminate), .vote_halt(vote_halt), .halt(halt)
  );

  function automatic logic [RW-1:0] exp_rank(input logic [RW-1:0] s);
    return BASE_R + (s >> 1) + (s >> 2) + (s >> 5);
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_rank(input int a, output logic [RW-1:0] d);
    @(negedge clk) rd_addr = 1'(a);
    @(negedge clk) d = rd_data;
  endtask

  task automatic run_pass(input logic [RW-1:0] s0, input logic [RW-1:0] s1, input logic exp_vote);
    logic [RW-1:0] sums [NL];
    sums[0] = s0;
    sums[1] = s1;
    @(negedge clk) compute = 1'b1;
    for (int i = 0; i < NL; i++) begin
      int t = 0;
      while (!sum_req && t < 50) begin @(negedge clk); t++; end
      check("R1 request seen", {31'd0, sum_req}, 32'd1);
      check("R1 vertex number", {29'd0, vertex_idx}, 32'(i * W + ID));
      sum_valid = 1'b1;
      sum_in    = sums[i];
      @(negedge clk) sum_valid = 1'b0;
    end
    begin
      int t = 0;
      while (!terminate && t < 20) begin @(negedge clk); t++; end
    end
    check("R6 terminate raised", {31'd0, terminate}, 32'd1);
    check("R5 vote", {31'd0, vote_halt}, {31'd0, exp_vote});
    repeat (3) @(negedge clk);
    check("R6 terminate held", {31'd0, terminate}, 32'd1);
    compute = 1'b0;
    @(negedge clk);
    check("R6 terminate cleared", {31'd0, terminate}, 32'd0);
  endtask

  task automatic t_reset_init();
    logic [RW-1:0] d;
    @(negedge clk);
    check("R2 sum_req in reset", {31'd0, sum_req}, 32'd0);
    check("R2 terminate in reset", {31'd0, terminate}, 32'd0);
    check("R2 vote in reset", {31'd0, vote_halt}, 32'd0);
    check("R2 halt in reset", {31'd0, halt}, 32'd0);
    rst = 1'b0;
    repeat (NL + 10) @(negedge clk);
    check("R6 idle without compute", {31'd0, sum_req}, 32'd0);
    for (int a = 0; a < NL; a++) begin
      read_rank(a, d);
      check("R2 init rank", d, INIT_R);
    end
  endtask

  task automatic t_zero_sums();
    logic [RW-1:0] d;
    run_pass('0, '0, 1'b0);
    for (int a = 0; a < NL; a++) begin
      read_rank(a, d);
      check("R8 zero sum gives base", d, BASE_R);
    end
  endtask

  task automatic t_update();
    logic [RW-1:0] d;
    run_pass(SA0, SA1, 1'b0);
    read_rank(0, d);
    check("R3 R4 rank of vertex 0", d, exp_rank(SA0));
    read_rank(1, d);
    check("R3 R4 rank of vertex 3", d, exp_rank(SA1));
  endtask

  task automatic t_partial_conv();
    logic [RW-1:0] d;
    // vertex 0 changes by exactly the threshold, vertex 3 by twice it
    run_pass(SA0 + 32, SA1 + 64, 1'b0);
    check("R7 no halt on partial vote", {31'd0, halt}, 32'd0);
    read_rank(0, d);
    check("R3 rank of vertex 0", d, exp_rank(SA0 + 32));
    read_rank(1, d);
    check("R3 rank of vertex 3", d, exp_rank(SA1 + 64));
  endtask

  task automatic t_full_conv();
    run_pass(SA0 + 64, SA1 + 64, 1'b1);
    check("R7 halt set", {31'd0, halt}, 32'd1);
  endtask

  task automatic t_halted_ignores();
    logic [RW-1:0] d;
    int seen = 0;
    @(negedge clk) compute = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (sum_req || terminate) seen++;
    end
    compute = 1'b0;
    check("R7 no pass after halt", 32'(seen), 32'd0);
    check("R7 halt stays", {31'd0, halt}, 32'd1);
    read_rank(0, d);
    check("R7 rank 0 unchanged", d, exp_rank(SA0 + 64));
    read_rank(1, d);
    check("R7 rank 3 unchanged", d, exp_rank(SA1 + 64));
  endtask

  initial begin
    t_reset_init();
    t_zero_sums();
    t_update();
    t_partial_conv();
    t_full_conv();
    t_halted_ignores();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule